// File: doc/BRIEF.md
# Serial-Clocked 24-Pin Open-Drain Port Expander

This block gives a host a set of open-drain general-purpose pins that are read and written over a three-wire serial link: a shift clock, an active-low select and a data line in one direction, with an open-drain data line in the other. All host signals, and an active-low set input, are sampled by a fast system clock. Each is passed through a two-flop synchronizer and then edge-detected, so the whole block runs in the system-clock domain.

A frame opens when the select falls. At that moment the pin levels are captured into a transmit register. Each pin level is the external level ANDed with the value the block itself drives. The captured word is sent out, pin 1 first, with one bit per falling shift-clock edge. On each rising shift-clock edge, a separate receive register takes in one serial bit. When the select rises, the receive register is copied into the output latch, which drives the pins. A latched 0 pulls a pin low. A latched 1 releases the pin, so it can be used as an input. Holding the set input low releases every pin and the serial output. It also puts the block back into its idle state.

Top module: `spx_expander`

## Requirements
- R1: After the synchronous reset, `pin_oe` and `sdo_oe` are all zero, so every pin and the serial output are released.
- R2: On a select falling edge, the transmit register takes `pin_in & L`, where L is the output latch (bit j is pin j+1).
- R3: After the k-th falling shift-clock edge of a frame (k = 1..24), `sdo_oe` equals the inverse of captured bit k-1. Before the first falling edge of a frame, `sdo_oe` is 0.
- R4: Each rising shift-clock edge that follows falling edge k (k = 1..24) shifts `sdi` into the receive register. The first bit received in a frame ends up at bit 0 (pin 1) once 24 bits have been received.
- R5: Shift-clock edges from the 25th pulse onward change neither the receive register nor anything else, and `sdo_oe` stays 0 while they arrive.
- R6: On a select rising edge, the receive register is copied into the output latch, and then `pin_oe` equals the inverse of the latch.
- R7: If the select rises after b < 24 received bits, the latch takes the receive register as it stands. The b new bits sit at bits 24-b..23, in arrival order from low to high, and the old contents are shifted down by b.
- R8: While `set_n` is low, `pin_oe` and `sdo_oe` are 0 and any frame is abandoned. The latch becomes all ones, and the receive register, the transmit register and the bit count are cleared.
- R9: If the select rise and a rising shift-clock edge are detected in the same system cycle, that bit is received first and is included in the latched word.
- R10: Shift-clock edges while the select is high have no effect on the receive register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Host shift clock, idle high, asynchronous |
| cs_n | input | 1 | Host frame select, active low, asynchronous |
| sdi | input | 1 | Host serial data into the block |
| set_n | input | 1 | Active-low set: releases all outputs and returns the block to idle |
| pin_in | input | 24 | Level seen on each pin (bit j is pin j+1) |
| pin_oe | output | 24 | 1 pulls the pin low, 0 releases it |
| sdo_oe | output | 1 | 1 pulls the serial output low, 0 releases it |

## Verification
The select's rising edge, which loads the latch, and a rising shift-clock edge, which shifts the receive register, can be detected in the same system cycle. The bench provokes this by changing `cs_n` and `sclk` at the same instant after a partial frame, so both pass through the synchronizers together. It judges the result from `pin_oe`, which must show the colliding bit as the last one received. A second overlap, the set input going low in the middle of a frame while the serial output is pulling low, is judged on both output enables and on the contents of the next latched word.

// File: rtl/spx_pkg.sv
package spx_pkg;
  typedef struct packed {
    logic cs_fall;
    logic cs_rise;
    logic ck_fall;
    logic ck_rise;
    logic set_act;
    logic sdi;
  } spx_evt_t;
endpackage

// File: rtl/spx_sync.sv
module spx_sync #(
  parameter int N = 4,
  parameter int STAGES = 2,
  parameter logic [N-1:0] IDLE = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] din,
  output logic [N-1:0] level,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  logic [STAGES-1:0][N-1:0] chain;
  logic [N-1:0]             last;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= {STAGES{IDLE}};
      last  <= IDLE;
    end else begin
      chain[0] <= din;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
      last <= chain[STAGES-1];
    end
  end

  assign level = chain[STAGES-1];
  assign rise  = level & ~last;
  assign fall  = ~level & last;
endmodule

// File: rtl/spx_ctrl.sv
module spx_ctrl
  import spx_pkg::*;
#(
  parameter int W = 24,
  localparam int CW = $clog2(W + 2)
) (
  input  logic     clk,
  input  logic     rst,
  input  spx_evt_t evt,
  output logic     load_tx,
  output logic     shift_tx,
  output logic     shift_rx,
  output logic     latch_rx,
  output logic     clr,
  output logic     bit_valid
);
  localparam logic [CW-1:0] LAST = CW'(W);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic          active;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || evt.set_act) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (evt.cs_rise) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (evt.cs_fall) begin
      active <= 1'b1;
      cnt    <= '0;
    end else if (active && evt.ck_fall && cnt <= LAST) begin
      cnt <= cnt + ONE;
    end
  end

  assign clr       = evt.set_act;
  assign bit_valid = active && cnt >= ONE && cnt <= LAST;
  assign load_tx   = evt.cs_fall && !evt.set_act;
  assign shift_tx  = active && evt.ck_fall && cnt >= ONE && cnt < LAST && !evt.set_act;
  assign shift_rx  = bit_valid && evt.ck_rise && !evt.set_act;
  assign latch_rx  = active && evt.cs_rise && !evt.set_act;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST + ONE); // R5
  AST_IDLE_CNT_ZERO: assert property (@(posedge clk) disable iff (rst)
    !active |-> cnt == '0); // R10
  AST_SET_ENDS_FRAME: assert property (@(posedge clk) disable iff (rst)
    evt.set_act |=> (!active && cnt == '0)); // R8
  AST_CNT_STOPS: assert property (@(posedge clk) disable iff (rst)
    (cnt == LAST + ONE && !evt.cs_rise && !evt.set_act) |=> cnt == LAST + ONE); // R5
endmodule

// File: rtl/spx_tx.sv
module spx_tx #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         load,
  input  logic         shift,
  input  logic [W-1:0] pin_word,
  output logic         bit_out
);
  logic [W-1:0] tx_q;

  always_ff @(posedge clk) begin
    if (rst || clr)   tx_q <= '0;
    else if (load)    tx_q <= pin_word;
    else if (shift)   tx_q <= {1'b0, tx_q[W-1:1]};
  end

  assign bit_out = tx_q[0];

  AST_TX_LOAD: assert property (@(posedge clk) disable iff (rst)
    (load && !clr) |=> tx_q == $past(pin_word)); // R2
  AST_TX_SHIFT: assert property (@(posedge clk) disable iff (rst)
    (shift && !load && !clr) |=> tx_q[W-2:0] == $past(tx_q[W-1:1])); // R3
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!shift && !load && !clr) |=> $stable(tx_q)); // R5
endmodule

// File: rtl/spx_rx.sv
module spx_rx #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         shift,
  input  logic         sdi,
  input  logic         latch_en,
  output logic [W-1:0] latch_q
);
  logic [W-1:0] rx_q;
  logic [W-1:0] rx_next;

  always_comb begin
    rx_next = rx_q;
    if (shift) rx_next = {sdi, rx_q[W-1:1]};
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      rx_q    <= '0;
      latch_q <= '1;
    end else begin
      rx_q <= rx_next;
      if (latch_en) latch_q <= rx_next;
    end
  end

  AST_RX_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!shift && !clr) |=> $stable(rx_q)); // R5
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!latch_en && !clr) |=> $stable(latch_q)); // R6
  AST_LATCH_ONES: assert property (@(posedge clk) disable iff (rst)
    clr |=> (&latch_q)); // R8
  AST_COLLIDE_BIT: assert property (@(posedge clk) disable iff (rst)
    (latch_en && shift && !clr) |=> latch_q[W-1] == $past(sdi)); // R9
endmodule

// File: rtl/spx_expander.sv
module spx_expander
  import spx_pkg::*;
#(
  parameter int W = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sclk,
  input  logic         cs_n,
  input  logic         sdi,
  input  logic         set_n,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] pin_oe,
  output logic         sdo_oe
);
  localparam int NSIG = 4;
  localparam int I_CK = 0;
  localparam int I_CS = 1;
  localparam int I_ST = 2;
  localparam int I_DI = 3;

  logic [NSIG-1:0] lvl, rise, fall;
  spx_evt_t        evt;
  logic            load_tx, shift_tx, shift_rx, latch_rx, clr, bit_valid;
  logic            tx_bit;
  logic [W-1:0]    latch_q;

  spx_sync #(.N(NSIG), .STAGES(SYNC_STAGES), .IDLE('1)) u_sync (
    .clk(clk), .rst(rst), .din({sdi, set_n, cs_n, sclk}),
    .level(lvl), .rise(rise), .fall(fall)
  );

  always_comb begin
    evt.cs_fall = fall[I_CS];
    evt.cs_rise = rise[I_CS];
    evt.ck_fall = fall[I_CK];
    evt.ck_rise = rise[I_CK];
    evt.set_act = ~lvl[I_ST];
    evt.sdi     = lvl[I_DI];
  end

  spx_ctrl #(.W(W)) u_ctrl (
    .clk(clk), .rst(rst), .evt(evt),
    .load_tx(load_tx), .shift_tx(shift_tx), .shift_rx(shift_rx),
    .latch_rx(latch_rx), .clr(clr), .bit_valid(bit_valid)
  );

  spx_tx #(.W(W)) u_tx (
    .clk(clk), .rst(rst), .clr(clr), .load(load_tx), .shift(shift_tx),
    .pin_word(pin_in & latch_q), .bit_out(tx_bit)
  );

  spx_rx #(.W(W)) u_rx (
    .clk(clk), .rst(rst), .clr(clr), .shift(shift_rx), .sdi(evt.sdi),
    .latch_en(latch_rx), .latch_q(latch_q)
  );

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      pin_oe <= '0;
      sdo_oe <= 1'b0;
    end else begin
      pin_oe <= ~latch_q;
      sdo_oe <= bit_valid && !tx_bit;
    end
  end

  AST_SET_FLOATS: assert property (@(posedge clk) disable iff (rst)
    evt.set_act |=> (pin_oe == '0 && !sdo_oe)); // R8
  AST_RESET_FLOATS: assert property (@(posedge clk)
    $past(rst) |-> (pin_oe == '0 && !sdo_oe)); // R1
  AST_SDO_ONLY_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
    (!bit_valid && !clr) |=> !sdo_oe); // R3
endmodule

// File: tb/tb_spx_expander.sv
module tb_spx_expander;
  localparam int W = 24;
  localparam int STEP = 6;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         sclk = 1'b1, cs_n = 1'b1, sdi = 1'b1, set_n = 1'b1;
  logic [W-1:0] ext = '1;
  logic [W-1:0] pin_in;
  logic [W-1:0] pin_oe;
  logic         sdo_oe;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [W-1:0] latch_m, rx_m;

  always #5 clk = ~clk;

  assign pin_in = ext & ~pin_oe;

  spx_expander #(.W(W)) dut (
    .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .sdi(sdi), .set_n(set_n),
    .pin_in(pin_in), .pin_oe(pin_oe), .sdo_oe(sdo_oe)
  );

  task automatic step();
    repeat (STEP) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // nbits falling/rising pulses; collide: final rise happens together with select rise
  task automatic frame(input logic [W-1:0] wr, input int nbits, input bit collide);
    logic [W-1:0] cap;
    int b;
    cap = ext & latch_m;
    cs_n = 1'b0; step();
    chk("R3 idle before first fall", {{(W-1){1'b0}}, sdo_oe}, '0);
    for (int k = 0; k < nbits; k++) begin
      sclk = 1'b0;
      sdi = (k < W) ? wr[k] : 1'b0;
      step();
      if (k < W) chk("R3 serial bit", {{(W-1){1'b0}}, sdo_oe}, {{(W-1){1'b0}}, ~cap[k]});
      else       chk("R5 released past 24", {{(W-1){1'b0}}, sdo_oe}, '0);
      if (collide && k == nbits - 1) begin
        sclk = 1'b1; cs_n = 1'b1; step();
      end else begin
        sclk = 1'b1; step();
      end
    end
    if (!(collide && nbits > 0)) begin
      cs_n = 1'b1; step();
    end
    b = (nbits > W) ? W : nbits;
    if (b == W) rx_m = wr;
    else if (b > 0) rx_m = (rx_m >> b) | ((wr & ((24'h1 << b) - 24'h1)) << (W - b));
    latch_m = rx_m;
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    latch_m = '1; rx_m = '0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0; step();
    chk("R1 pins released", pin_oe, '0);
    chk("R1 serial released", {{(W-1){1'b0}}, sdo_oe}, '0);

    // R4 / R6: first full frame
    ext = 24'hFFFFFF;
    frame(24'hA5C30F, W, 0);
    chk("R4 R6 full frame latched", pin_oe, ~latch_m);

    // R10: toggling while deselected, then empty frame
    for (int k = 0; k < 3; k++) begin
      sclk = 1'b0; sdi = 1'b0; step();
      sclk = 1'b1; step();
    end
    frame('0, 0, 0);
    chk("R10 deselected clocks ignored", pin_oe, ~24'hA5C30F);

    // R2 / R3 sweep: walking zero written, varying external levels
    for (int i = 0; i < W; i++) begin
      ext = ~(24'h1 << ((i * 7) % W)) ^ (24'h000111 << (i % 8));
      frame(~(24'h1 << i) ^ (24'h030000 * i[7:0]), W, 0);
      chk("R2 R6 sweep latch", pin_oe, ~latch_m);
    end

    // R5: over-clocked frame
    ext = 24'hF0F0F0;
    frame(24'h3C5AA5, W + 2, 0);
    chk("R5 extra pulses ignored", pin_oe, ~latch_m);

    // R7: partial frames
    frame(24'h000015, 5, 0);
    chk("R7 partial 5 bits", pin_oe, ~latch_m);
    frame(24'h000ABC, 13, 0);
    chk("R7 partial 13 bits", pin_oe, ~latch_m);

    // R9: select rise collides with a rising clock edge
    frame(24'h0001B5, 9, 1);
    chk("R9 colliding bit included", pin_oe, ~latch_m);

    // R8: set low mid-frame while serial output pulls low
    ext = 24'h000000;
    cs_n = 1'b0; step();
    sclk = 1'b0; step();
    chk("R8 serial pulling before set", {{(W-1){1'b0}}, sdo_oe}, 24'h1);
    set_n = 1'b0; step();
    chk("R8 pins released by set", pin_oe, '0);
    chk("R8 serial released by set", {{(W-1){1'b0}}, sdo_oe}, '0);
    set_n = 1'b1; sclk = 1'b1; cs_n = 1'b1; step();
    latch_m = '1; rx_m = '0;
    chk("R8 latch ones after set", pin_oe, '0);
    ext = 24'hFFFFFF;
    frame('0, 0, 0);
    chk("R8 receive cleared by set", pin_oe, 24'hFFFFFF);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule